// File: doc/BRIEF.md
# Conditional Branch Sequencer with IF Stack

This block owns the program counter of a small shader sequencer and resolves structured IF instructions. For an IF it forms two partial results by matching reference bits against the two condition-code flags, then merges them with a selectable operator. A true condition falls into the then-part and records a hidden stack entry of (else address, else length). A false condition jumps straight to the else address.

No instruction marks the end of a then-part. After every executed instruction, the freshly updated counter is compared with the else address of the newest stack entry. On a match, the else length is added to the counter and the entry is discarded, so the else-part is stepped over. The stack has eight entries. A run-start pulse empties it and loads an entry address, as reset does. Any pipeline front end can use the block by pulsing `step` once per retired instruction, with the decoded IF fields alongside.

Top module: `cond_branch_seq`

## Requirements
- R1: The condition is computed as px = (ref_x == cc_x) and py = (ref_y == cc_y), combined by comb_op: 0 gives px OR py, 1 gives px AND py, 2 gives px alone, 3 gives py alone.
- R2: A step with is_if high and a true condition sets pc to pc+1 and pushes (dest_addr, else_len), which raises depth by one.
- R3: A step with is_if high and a false condition sets pc to dest_addr and pushes nothing.
- R4: A step with is_if low advances pc by one (modulo 4096) when inc_en is high and holds it when inc_en is low.
- R5: After the normal update of a step, if the stack is non-empty and the new pc equals the newest entry's else address, pc becomes that address plus the entry's else length and the entry is popped. At most one such skip happens per step, even when the next entry also matches.
- R6: An entry pushed in a step is already the newest entry for that step's skip check. If dest_addr equals pc+1, pc becomes pc+1+else_len and depth is unchanged.
- R7: A push while depth is 8 is dropped. The sticky overflow output is set, pc still becomes pc+1, and depth stays 8.
- R8: Reset and run_start each set pc to entry_pc, depth to 0 and overflow to 0. run_start takes priority over step.
- R9: In a cycle without step or run_start, pc, depth and overflow keep their values.
- R10: depth never exceeds 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_start | input | 1 | Starts a new run: loads entry_pc and empties the stack |
| entry_pc | input | 12 | Start address loaded by reset and run_start |
| step | input | 1 | One instruction retires this cycle |
| inc_en | input | 1 | Normal increment enable for a non-IF instruction |
| is_if | input | 1 | The retiring instruction is a conditional IF |
| ref_x | input | 1 | Reference bit matched against cc_x |
| ref_y | input | 1 | Reference bit matched against cc_y |
| comb_op | input | 2 | Combine operator (0 OR, 1 AND, 2 x only, 3 y only) |
| dest_addr | input | 12 | IF destination, which is the else address |
| else_len | input | 8 | Number of else instructions to skip |
| cc_x | input | 1 | Condition-code flag 0 |
| cc_y | input | 1 | Condition-code flag 1 |
| pc | output | 12 | Program counter |
| depth | output | 4 | Number of live stack entries, 0 to 8 |
| overflow | output | 1 | Sticky flag for a dropped push |

## Verification
Two functions can fall in the same step: the push of a true IF and the skip check against the stack top. The bench provokes the overlap in two ways. It issues a true IF whose destination is the next address, and it fills the stack to its limit before issuing one more true IF. The expected results are, respectively, an immediate skip with an unchanged depth, and a dropped push with a plain fall-through. A second overlap is two stacked entries that share an else address. Here the bench checks that a single step consumes only one of them, and that the other is consumed by a following non-incrementing step.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

  typedef enum logic [1:0] {
    CMB_OR  = 2'd0,
    CMB_AND = 2'd1,
    CMB_X   = 2'd2,
    CMB_Y   = 2'd3
  } comb_op_e;

  // one partial result: reference bit equal to its flag
  function automatic logic flag_match(input logic ref_bit, input logic flag);
    return ref_bit == flag;
  endfunction

  // merge of the two partial results
  function automatic logic cond_combine(input logic px, input logic py,
                                        input logic [1:0] op);
    logic r;
    case (comb_op_e'(op))
      CMB_OR:  r = px | py;
      CMB_AND: r = px & py;
      CMB_X:   r = px;
      default: r = py;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cbs_cond_eval.sv
module cbs_cond_eval
  import cbs_pkg::*;
(
  input  logic       ref_x,
  input  logic       ref_y,
  input  logic       cc_x,
  input  logic       cc_y,
  input  logic [1:0] comb_op,
  output logic       part_x,
  output logic       part_y,
  output logic       cond_true
);

  always_comb begin
    part_x    = flag_match(ref_x, cc_x);
    part_y    = flag_match(ref_y, cc_y);
    cond_true = cond_combine(part_x, part_y, comb_op);
  end

endmodule

// File: rtl/cbs_if_stack.sv
module cbs_if_stack #(
  parameter int DEPTH = 8,
  parameter int AW    = 12,
  parameter int LW    = 8,
  localparam int DW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_addr,
  input  logic [LW-1:0] push_len,
  output logic [AW-1:0] top_addr,
  output logic [LW-1:0] top_len,
  output logic [DW-1:0] depth,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] depth_q;
  logic [AW-1:0] addr_arr [DEPTH];
  logic [LW-1:0] len_arr  [DEPTH];
  logic [IW-1:0] top_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [AW-1:0] a_q;
    logic [LW-1:0] l_q;
    logic          wr_here;
    logic          kill_here;

    assign wr_here   = push && (depth_q == DW'(g));
    assign kill_here = pop  && (depth_q == DW'(g + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q <= '1;
        l_q <= '1;
      end else if (clear || kill_here) begin
        a_q <= '1;
        l_q <= '1;
      end else if (wr_here) begin
        a_q <= push_addr;
        l_q <= push_len;
      end
    end

    assign addr_arr[g] = a_q;
    assign len_arr[g]  = l_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
    end else if (clear) begin
      depth_q <= '0;
    end else if (push && !pop && !full) begin
      depth_q <= depth_q + 1'b1;
    end else if (pop && !push && !empty) begin
      depth_q <= depth_q - 1'b1;
    end
  end

  always_comb begin
    top_idx  = IW'(depth_q - 1'b1);
    empty    = (depth_q == '0);
    full     = (depth_q == DW'(DEPTH));
    top_addr = empty ? '1 : addr_arr[top_idx];
    top_len  = empty ? '1 : len_arr[top_idx];
    depth    = depth_q;
  end

endmodule

// File: rtl/cbs_pc_step.sv
module cbs_pc_step #(
  parameter int AW = 12,
  parameter int LW = 8
) (
  input  logic [AW-1:0] pc,
  input  logic          is_if,
  input  logic          inc_en,
  input  logic          cond_true,
  input  logic [AW-1:0] dest_addr,
  input  logic [LW-1:0] else_len,
  input  logic          stk_empty,
  input  logic          stk_full,
  input  logic [AW-1:0] top_addr,
  input  logic [LW-1:0] top_len,
  output logic          push_ok,
  output logic          push_drop,
  output logic          skip_hit,
  output logic          stk_push,
  output logic          stk_pop,
  output logic [AW-1:0] next_pc
);

  function automatic logic [AW-1:0] pc_inc(input logic [AW-1:0] p);
    return p + AW'(1);
  endfunction

  function automatic logic [AW-1:0] pc_skip(input logic [AW-1:0] p,
                                            input logic [LW-1:0] n);
    return p + AW'(n);
  endfunction

  logic [AW-1:0] base_pc;
  logic          want_push;
  logic [AW-1:0] cmp_addr;
  logic [LW-1:0] cmp_len;
  logic          cmp_valid;

  always_comb begin
    want_push = is_if && cond_true;
    push_ok   = want_push && !stk_full;
    push_drop = want_push && stk_full;

    if (is_if) begin
      base_pc = cond_true ? pc_inc(pc) : dest_addr;
    end else begin
      base_pc = inc_en ? pc_inc(pc) : pc;
    end

    // the entry written in this step is already the newest one
    cmp_valid = push_ok || !stk_empty;
    cmp_addr  = push_ok ? dest_addr : top_addr;
    cmp_len   = push_ok ? else_len  : top_len;

    skip_hit  = cmp_valid && (base_pc == cmp_addr);
    next_pc   = skip_hit ? pc_skip(base_pc, cmp_len) : base_pc;

    stk_push  = push_ok && !skip_hit;
    stk_pop   = skip_hit && !push_ok;
  end

endmodule

// File: rtl/cond_branch_seq.sv
module cond_branch_seq #(
  parameter int AW    = 12,
  parameter int LW    = 8,
  parameter int DEPTH = 8,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_start,
  input  logic [AW-1:0] entry_pc,
  input  logic          step,
  input  logic          inc_en,
  input  logic          is_if,
  input  logic          ref_x,
  input  logic          ref_y,
  input  logic [1:0]    comb_op,
  input  logic [AW-1:0] dest_addr,
  input  logic [LW-1:0] else_len,
  input  logic          cc_x,
  input  logic          cc_y,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] depth,
  output logic          overflow
);

  // named internal events
  logic          part_x;
  logic          part_y;
  logic          cond_true;
  logic          push_ok;
  logic          push_drop;
  logic          skip_hit;
  logic          stk_push;
  logic          stk_pop;
  logic [AW-1:0] next_pc;
  logic [AW-1:0] top_addr;
  logic [LW-1:0] top_len;
  logic          stk_full;
  logic          stk_empty;
  logic          do_push;
  logic          do_pop;

  logic [AW-1:0] pc_q;
  logic          ovf_q;

  cbs_cond_eval u_cond (
    .ref_x     (ref_x),
    .ref_y     (ref_y),
    .cc_x      (cc_x),
    .cc_y      (cc_y),
    .comb_op   (comb_op),
    .part_x    (part_x),
    .part_y    (part_y),
    .cond_true (cond_true)
  );

  cbs_pc_step #(.AW(AW), .LW(LW)) u_step (
    .pc        (pc_q),
    .is_if     (is_if),
    .inc_en    (inc_en),
    .cond_true (cond_true),
    .dest_addr (dest_addr),
    .else_len  (else_len),
    .stk_empty (stk_empty),
    .stk_full  (stk_full),
    .top_addr  (top_addr),
    .top_len   (top_len),
    .push_ok   (push_ok),
    .push_drop (push_drop),
    .skip_hit  (skip_hit),
    .stk_push  (stk_push),
    .stk_pop   (stk_pop),
    .next_pc   (next_pc)
  );

  assign do_push = step && !run_start && stk_push;
  assign do_pop  = step && !run_start && stk_pop;

  cbs_if_stack #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (run_start),
    .push      (do_push),
    .pop       (do_pop),
    .push_addr (dest_addr),
    .push_len  (else_len),
    .top_addr  (top_addr),
    .top_len   (top_len),
    .depth     (depth),
    .full      (stk_full),
    .empty     (stk_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= entry_pc;
      ovf_q <= 1'b0;
    end else if (run_start) begin
      pc_q  <= entry_pc;
      ovf_q <= 1'b0;
    end else if (step) begin
      pc_q  <= next_pc;
      ovf_q <= ovf_q | push_drop;
    end
  end

  assign pc       = pc_q;
  assign overflow = ovf_q;

endmodule

// File: rtl/cbs_checker.sv
module cbs_checker #(
  parameter int AW    = 12,
  parameter int DEPTH = 8,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_start,
  input logic          step,
  input logic          is_if,
  input logic [AW-1:0] entry_pc,
  input logic [AW-1:0] dest_addr,
  input logic          cond_true,
  input logic          skip_hit,
  input logic [AW-1:0] pc,
  input logic [DW-1:0] depth,
  input logic          overflow
);

  AST_FALSE_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && is_if && !cond_true && !skip_hit && !run_start) |=> pc == $past(dest_addr)); // R3

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && is_if && cond_true && depth < DW'(DEPTH) && !skip_hit && !run_start)
    |=> depth == $past(depth) + 1'b1); // R2

  AST_SKIP_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && skip_hit && !(is_if && cond_true && depth < DW'(DEPTH)) && !run_start)
    |=> depth == $past(depth) - 1'b1); // R5

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !run_start) |=> overflow); // R7

  AST_RUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> (depth == '0) && !overflow && pc == $past(entry_pc)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !run_start) |=> $stable(pc) && $stable(depth) && $stable(overflow)); // R9

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(DEPTH)); // R10

endmodule

bind cond_branch_seq cbs_checker #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_start (run_start),
  .step      (step),
  .is_if     (is_if),
  .entry_pc  (entry_pc),
  .dest_addr (dest_addr),
  .cond_true (cond_true),
  .skip_hit  (skip_hit),
  .pc        (pc),
  .depth     (depth),
  .overflow  (overflow)
);

// File: tb/cond_branch_seq_bench.sv
module cond_branch_seq_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_start = 1'b0;
  logic [11:0] entry_pc = 12'd0;
  logic        step = 1'b0;
  logic        inc_en = 1'b0;
  logic        is_if = 1'b0;
  logic        ref_x = 1'b0;
  logic        ref_y = 1'b0;
  logic [1:0]  comb_op = 2'd0;
  logic [11:0] dest_addr = 12'd0;
  logic [7:0]  else_len = 8'd0;
  logic        cc_x = 1'b0;
  logic        cc_y = 1'b0;
  logic [11:0] pc;
  logic [3:0]  depth;
  logic        overflow;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cond_branch_seq u_cond_branch_seq (
    .clk(clk), .rst_n(rst_n), .run_start(run_start), .entry_pc(entry_pc),
    .step(step), .inc_en(inc_en), .is_if(is_if), .ref_x(ref_x), .ref_y(ref_y),
    .comb_op(comb_op), .dest_addr(dest_addr), .else_len(else_len),
    .cc_x(cc_x), .cc_y(cc_y), .pc(pc), .depth(depth), .overflow(overflow)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_run(input int addr);
    @(negedge clk);
    entry_pc  = 12'(addr);
    run_start = 1'b1;
    @(negedge clk);
    run_start = 1'b0;
  endtask

  task automatic plain_step(input bit inc);
    @(negedge clk);
    is_if  = 1'b0;
    inc_en = inc;
    step   = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic if_step(input bit rx, input bit ry, input int op,
                         input int dst, input int len);
    @(negedge clk);
    is_if     = 1'b1;
    inc_en    = 1'b1;
    ref_x     = rx;
    ref_y     = ry;
    comb_op   = 2'(op);
    dest_addr = 12'(dst);
    else_len  = 8'(len);
    step      = 1'b1;
    @(negedge clk);
    step  = 1'b0;
    is_if = 1'b0;
  endtask

  // bench-side condition: count matching flags
  function automatic bit expect_cond(bit rx, bit ry, bit fx, bit fy, int op);
    int hits;
    bit mx;
    bit my;
    mx   = (rx ^ fx) == 1'b0;
    my   = (ry ^ fy) == 1'b0;
    hits = int'(mx) + int'(my);
    if (op == 0) return hits > 0;
    if (op == 1) return hits == 2;
    if (op == 2) return mx;
    return my;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    entry_pc = 12'd33;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 reset pc", pc, 33);
    check("R8 reset depth", depth, 0);
    check("R8 reset overflow", overflow, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 idle cycles hold
    repeat (4) @(negedge clk);
    check("R9 idle pc", pc, 33);
    check("R9 idle depth", depth, 0);

    // R1 R2 R3 sweep over every condition input
    for (int code = 0; code < 64; code++) begin
      bit rx, ry, fx, fy, c;
      int op;
      rx = code[0]; ry = code[1]; fx = code[2]; fy = code[3]; op = code[5:4];
      start_run(100);
      cc_x = fx; cc_y = fy;
      if_step(rx, ry, op, 200, 5);
      c = expect_cond(rx, ry, fx, fy, op);
      if (c) begin
        check("R1 R2 true pc", pc, 101);
        check("R2 true depth", depth, 1);
      end else begin
        check("R1 R3 false pc", pc, 200);
        check("R3 false depth", depth, 0);
      end
    end

    // condition forced true: op 2 with ref_x equal to cc_x
    cc_x = 1'b1; cc_y = 1'b0;

    // R5 then-part end skips the else-part
    start_run(0);
    if_step(1, 0, 2, 3, 4);
    check("R2 push pc", pc, 1);
    plain_step(1);
    plain_step(1);
    check("R5 skip pc", pc, 7);
    check("R5 skip depth", depth, 0);

    // R6 push and skip in one step
    if_step(1, 0, 2, 8, 2);
    check("R6 same-step skip pc", pc, 10);
    check("R6 same-step depth", depth, 0);

    // R5 only one pop per step, then R4 hold step still checked
    start_run(0);
    if_step(1, 0, 2, 5, 3);
    if_step(1, 0, 2, 5, 0);
    check("R2 two pushes depth", depth, 2);
    plain_step(1);
    plain_step(1);
    plain_step(1);
    check("R5 single pop pc", pc, 5);
    check("R5 single pop depth", depth, 1);
    plain_step(0);
    check("R5 second pop pc", pc, 8);
    check("R5 second pop depth", depth, 0);
    plain_step(0);
    check("R4 hold pc", pc, 8);

    // R7 overflow
    start_run(0);
    for (int k = 0; k < 8; k++) if_step(1, 0, 2, 4000, 1);
    check("R10 full depth", depth, 8);
    check("R7 no overflow yet", overflow, 0);
    if_step(1, 0, 2, 4000, 1);
    check("R7 drop pc", pc, 9);
    check("R7 drop depth", depth, 8);
    check("R7 overflow set", overflow, 1);
    plain_step(1);
    check("R7 overflow sticky", overflow, 1);
    check("R4 step pc", pc, 10);
    start_run(50);
    check("R8 run pc", pc, 50);
    check("R8 run depth", depth, 0);
    check("R8 run overflow", overflow, 0);

    // R4 wrap
    start_run(4095);
    plain_step(1);
    check("R4 wrap pc", pc, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule